// File: doc/BRIEF.md
# Pipelined Packed Byte Multiplier

This unit multiplies two 32-bit words as four independent 8-bit lanes: lane i of operand A is multiplied by lane i of operand B, giving four 16-bit products in one pass. A two-bit operation code chooses what is returned. The unit can return the low byte of every product or the high byte of every product, each in its own byte lane. It can also add adjacent products in pairs to give two 16-bit sums. A signedness input decides whether the lanes are read as two's-complement or unsigned values.

The datapath has two register stages. The first stage forms the four lane products. The second stage selects bytes or adds pairs, and holds the result. Operands enter and results leave through valid/ready streams. An operand word is taken on a rising edge where `in_valid` and `in_ready` are both high. A result is handed over on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the result and `out_valid` hold steady. `in_ready` is a combinational function of pipeline occupancy and `out_ready`, so it falls only when both stages are full and the consumer is stalling. The plain `flush` input empties both stages.

Top module: `pmul_core`

## Requirements
- R1: While `rst_n` is low and after it is released, with nothing issued, `out_valid` is 0 and `in_ready` is 1.
- R2: `in_op` = 2'b00 (multiply-low) puts bits 7:0 of the product of lane i (bits 8i+7:8i) into result byte lane i.
- R3: `in_op` = 2'b01 (multiply-high) puts bits 15:8 of the product of lane i into result byte lane i.
- R4: `in_op` = 2'b10 (multiply-add) returns A1*B1 + A0*B0 in bits 15:0 and A3*B3 + A2*B2 in bits 31:16. Each sum is taken modulo 2^16, with no saturation.
- R5: `in_op` = 2'b11 returns the same result as multiply-low.
- R6: With `in_signed` = 1 every lane is a two's-complement value; with `in_signed` = 0 every lane is unsigned.
- R7: An operand word accepted on edge k with no flush on edges k and k+1 makes `out_valid` high after edge k+1. With `out_ready` held high, one word is accepted every cycle and the results come out in order, back to back.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` hold. `in_ready` is 0 only when the unit holds a result and `out_ready` is 0. No result is lost or duplicated across a stall.
- R9: `flush` high on an edge empties both stages, so `out_valid` is 0 after that edge. A word presented with `flush` high is discarded.
- R10: The operation code, the signedness and the operands are captured at acceptance. Later changes on these inputs do not alter results already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of both pipeline stages |
| in_valid | input | 1 | Operand word present |
| in_ready | output | 1 | Unit can accept an operand word this cycle |
| in_a | input | 32 | Operand A, four 8-bit lanes |
| in_b | input | 32 | Operand B, four 8-bit lanes |
| in_op | input | 2 | 00 low byte, 01 high byte, 10 pairwise add, 11 as 00 |
| in_signed | input | 1 | 1 two's-complement lanes, 0 unsigned lanes |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 32 | Result word |

## Verification
The properties assume a well-behaved consumer: `out_ready` may fall at any time, and `flush` is the only way to discard a held result. The latency property also assumes no flush in the cycle after acceptance. The bench changes `in_*` and `out_ready` only at falling edges, so every handshake is decided on stable values. It raises `flush` only in the dedicated flush test, never while a stall is being checked. During stalls it keeps `in_valid` asserted with unchanged operands until the word is accepted, as a valid/ready producer must.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
  typedef enum logic [1:0] {
    PM_LOW  = 2'b00,
    PM_HIGH = 2'b01,
    PM_MADD = 2'b10,
    PM_ALT  = 2'b11
  } pm_op_e;
endpackage

// File: rtl/pmul_lane.sv
// One lane: extends both bytes to product width (sign or zero) and multiplies.
module pmul_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           sgn,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;
  logic [PW-1:0] ax, bx;
  assign ax   = {{W{sgn & a[W-1]}}, a};
  assign bx   = {{W{sgn & b[W-1]}}, b};
  // low PW bits of a PW x PW product are exact for both interpretations
  assign prod = ax * bx;
endmodule

// File: rtl/pmul_products.sv
// Stage-one datapath: LANES parallel lane multipliers.
module pmul_products #(
  parameter int LANES = 4,
  parameter int W     = 8
) (
  input  logic [LANES*W-1:0]   a,
  input  logic [LANES*W-1:0]   b,
  input  logic                 sgn,
  output logic [LANES*2*W-1:0] prods
);
  localparam int PW = 2 * W;
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    pmul_lane #(.W(W)) u_lane (
      .a    (a[l*W +: W]),
      .b    (b[l*W +: W]),
      .sgn  (sgn),
      .prod (prods[l*PW +: PW])
    );
  end
endmodule

// File: rtl/pmul_select.sv
// Stage-two datapath: byte pick per lane or pairwise sum of products.
module pmul_select #(
  parameter int LANES = 4,
  parameter int W     = 8
) (
  input  pmul_pkg::pm_op_e     op,
  input  logic [LANES*2*W-1:0] prods,
  output logic [LANES*W-1:0]   res
);
  import pmul_pkg::*;
  localparam int PW    = 2 * W;
  localparam int PAIRS = LANES / 2;

  logic [LANES*W-1:0] lo_bytes, hi_bytes, sums;

  for (genvar l = 0; l < LANES; l++) begin : g_pick
    assign lo_bytes[l*W +: W] = prods[l*PW +: W];
    assign hi_bytes[l*W +: W] = prods[l*PW + W +: W];
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    // wraps modulo 2^PW by the width of the destination
    assign sums[p*PW +: PW] = prods[(2*p)*PW +: PW] + prods[(2*p+1)*PW +: PW];
  end

  always_comb begin
    unique case (op)
      PM_HIGH: res = hi_bytes;
      PM_MADD: res = sums;
      default: res = lo_bytes;
    endcase
  end
endmodule

// File: rtl/pmul_core.sv
// Two-stage packed multiplier with valid/ready streams on both sides.
module pmul_core #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*LANE_W-1:0] in_a,
  input  logic [LANES*LANE_W-1:0] in_b,
  input  logic [1:0]              in_op,
  input  logic                    in_signed,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*LANE_W-1:0] out_data
);
  import pmul_pkg::*;
  localparam int DW    = LANES * LANE_W;
  localparam int PRODW = LANES * 2 * LANE_W;

  // stage one state
  logic             s1_valid;
  logic [PRODW-1:0] s1_prods;
  pm_op_e           s1_op;
  // stage two state
  logic             s2_valid;
  logic [DW-1:0]    s2_res;

  logic             s2_move, take_in;
  logic [PRODW-1:0] prods_nxt;
  logic [DW-1:0]    res_nxt;

  assign s2_move  = !s2_valid || out_ready;
  assign in_ready = !s1_valid || s2_move;
  assign take_in  = in_valid && in_ready;

  pmul_products #(.LANES(LANES), .W(LANE_W)) u_prod (
    .a     (in_a),
    .b     (in_b),
    .sgn   (in_signed),
    .prods (prods_nxt)
  );

  pmul_select #(.LANES(LANES), .W(LANE_W)) u_sel (
    .op    (s1_op),
    .prods (s1_prods),
    .res   (res_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_prods <= '0;
      s1_op    <= PM_LOW;
    end else if (flush) begin
      s1_valid <= 1'b0;
    end else if (in_ready) begin
      s1_valid <= in_valid;
      if (take_in) begin
        s1_prods <= prods_nxt;
        s1_op    <= pm_op_e'(in_op);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_res   <= '0;
    end else if (flush) begin
      s2_valid <= 1'b0;
    end else if (s2_move) begin
      s2_valid <= s1_valid;
      if (s1_valid) s2_res <= res_nxt;
    end
  end

  assign out_valid = s2_valid;
  assign out_data  = s2_res;
endmodule

// File: rtl/pmul_core_chk.sv
module pmul_core_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data
);
  // R1: reset leaves the output side idle
  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R7: an accepted word is visible one edge later unless flushed
  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !flush) ##1 !flush |=> out_valid);

  // R8: a stalled result holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_data)));

  // R8: input back-pressure only with a stalled result
  a_r8_ready_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (out_valid && !out_ready));

  // R9: flush empties the pipeline
  a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);
endmodule

bind pmul_core pmul_core_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/pmul_core_test.sv
`timescale 1ns/1ps
module pmul_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_a = '0, in_b = '0;
  logic [1:0]  in_op = 2'b00;
  logic        in_signed = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;

  int nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  pmul_core uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_op(in_op), .in_signed(in_signed),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // stimulus: {op, signed, a, b}
  localparam int NV = 10;
  localparam logic [66:0] VEC [NV] = '{
    {2'b00, 1'b0, 32'h0210FF03, 32'h0310FF05},
    {2'b01, 1'b0, 32'h0210FF03, 32'h0310FF05},
    {2'b10, 1'b0, 32'h0210FF03, 32'h0310FF05},
    {2'b01, 1'b1, 32'h0210FF03, 32'h0310FF05},
    {2'b10, 1'b1, 32'h0210FF03, 32'h0310FF05},
    {2'b11, 1'b1, 32'h807F80FF, 32'h80807F01},
    {2'b01, 1'b1, 32'h807F80FF, 32'h80807F01},
    {2'b10, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF},
    {2'b10, 1'b1, 32'h80808080, 32'h80808080},
    {2'b00, 1'b1, 32'h00000000, 32'h12345678}
  };

  // behavioural model written from R2..R6
  function automatic logic [31:0] model(input logic [1:0] op, input logic sg,
                                       input logic [31:0] a, input logic [31:0] b);
    logic [15:0] p [4];
    logic [31:0] r;
    for (int l = 0; l < 4; l++) begin
      int xa, xb;
      xa = sg ? int'($signed(a[8*l +: 8])) : int'(a[8*l +: 8]);
      xb = sg ? int'($signed(b[8*l +: 8])) : int'(b[8*l +: 8]);
      p[l] = 16'(xa * xb);
    end
    case (op)
      2'b01:   r = {p[3][15:8], p[2][15:8], p[1][15:8], p[0][15:8]};
      2'b10:   r = {16'(p[3] + p[2]), 16'(p[1] + p[0])};
      default: r = {p[3][7:0], p[2][7:0], p[1][7:0], p[0][7:0]};
    endcase
    return r;
  endfunction

  function automatic string tag(input logic [1:0] op);
    case (op)
      2'b00: return "R2 R6";
      2'b01: return "R3 R6";
      2'b10: return "R4 R6";
      default: return "R5 R6";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [66:0] v, input logic vld);
    in_valid  = vld;
    in_op     = v[66:65];
    in_signed = v[64];
    in_a      = v[63:32];
    in_b      = v[31:0];
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", 32'(out_valid), 32'd0);
    chk("R1 in_ready after reset", 32'(in_ready), 32'd1);

    // streamed table, back to back (R7)
    out_ready = 1'b1;
    for (int j = 0; j < NV + 2; j++) begin
      if (j >= 2) begin
        chk("R7 out_valid streamed", 32'(out_valid), 32'd1);
        chk(tag(VEC[j-2][66:65]), out_data,
            model(VEC[j-2][66:65], VEC[j-2][64], VEC[j-2][63:32], VEC[j-2][31:0]));
      end
      if (j < NV) drive(VEC[j], 1'b1);
      else        in_valid = 1'b0;
      @(negedge clk);
    end
    chk("R7 idle after stream", 32'(out_valid), 32'd0);

    // hand-worked values
    drive(VEC[0], 1'b1); @(negedge clk); in_valid = 1'b0; @(negedge clk);
    chk("R2 unsigned low", out_data, 32'h0600010F);
    drive(VEC[3], 1'b1); @(negedge clk); in_valid = 1'b0; @(negedge clk);
    chk("R3 R6 signed high", out_data, 32'h00010000);
    drive(VEC[4], 1'b1); @(negedge clk); in_valid = 1'b0; @(negedge clk);
    chk("R4 R6 signed madd", out_data, 32'h01060010);
    drive(VEC[7], 1'b1); @(negedge clk); in_valid = 1'b0; @(negedge clk);
    chk("R4 unsigned wrap", out_data, 32'hFC02FC02);
    drive(VEC[8], 1'b1); @(negedge clk); in_valid = 1'b0; @(negedge clk);
    chk("R4 signed no saturation", out_data, 32'h80008000);
    drive({2'b11, VEC[0][64:0]}, 1'b1); @(negedge clk); in_valid = 1'b0; @(negedge clk);
    chk("R5 op 11 as low", out_data, 32'h0600010F);
    @(negedge clk);

    // back-pressure (R8) and capture at acceptance (R10)
    out_ready = 1'b0;
    drive(VEC[0], 1'b1); @(negedge clk);
    drive(VEC[1], 1'b1); @(negedge clk);
    drive(VEC[2], 1'b1);
    chk("R8 first result shown", out_data, 32'h0600010F);
    chk("R8 in_ready low when full", 32'(in_ready), 32'd0);
    @(negedge clk);
    chk("R8 out_valid held", 32'(out_valid), 32'd1);
    chk("R8 out_data held", out_data, 32'h0600010F);
    chk("R8 in_ready still low", 32'(in_ready), 32'd0);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R8 second result in order", out_data, 32'h0001FE00);
    drive({2'b00, 1'b1, 32'hDEADBEEF, 32'h55AA55AA}, 1'b0);
    @(negedge clk);
    chk("R10 R8 third result unaffected", out_data, 32'h0106FE10);
    @(negedge clk);
    chk("R8 no duplicate", 32'(out_valid), 32'd0);

    // flush (R9)
    drive(VEC[0], 1'b1); @(negedge clk);
    drive(VEC[1], 1'b1); flush = 1'b1; @(negedge clk);
    chk("R9 empty after flush", 32'(out_valid), 32'd0);
    flush = 1'b0; in_valid = 1'b0; @(negedge clk);
    chk("R9 flushed word dropped", 32'(out_valid), 32'd0);
    drive(VEC[2], 1'b1); @(negedge clk); in_valid = 1'b0; @(negedge clk);
    chk("R9 works after flush", out_data, 32'h0106FE10);

    finish_run();
  end
endmodule